// File: doc/BRIEF.md
# Byte SEC-DED Error Correcting Codec

This block protects bytes held in a memory with a single-error-correcting, double-error-detecting code. It has two independent channels. The encode channel takes a data byte and returns five check bits to store next to it. The decode channel takes a stored byte and its five check bits. It returns the byte after correction, a flag for a corrected single error, a flag for an uncorrectable error, and the Hamming syndrome.

The code uses a 12-position Hamming layout. Positions 1, 2, 4 and 8 hold Hamming parity bits. The eight data bits fill the remaining positions in ascending order. A fifth check bit gives even parity over the whole word, which allows a double error to be told apart from a single one.

Each channel passes through one registered stage with a valid/ready handshake. A result appears on the output one cycle after its input is accepted. It stays there unchanged until the consumer takes it.

Top module: `secded_codec`

## Requirements
- R1: Data bit k (k = 0..7) occupies code position 3, 5, 6, 7, 9, 10, 11, 12 respectively. Encoder check bit i (i = 0..3) is the even parity of the data bits whose code position has bit i set. It stands for code position 2^i. The encoder also returns its input byte unchanged.
- R2: Encoder check bit 4 is the XOR of all 12 code positions, so the full 13-bit stored word has even parity.
- R3: A stored word with no error decodes to its own data byte, with syndrome 0 and both flags low.
- R4: A single flipped data bit is corrected. The single flag is high, the double flag is low, and the syndrome equals the code position of the flipped bit.
- R5: A single flipped Hamming check bit (positions 1, 2, 4, 8) leaves the data unchanged. The single flag is high and the syndrome equals that position.
- R6: A flip of check bit 4 alone gives syndrome 0 and the single flag, and leaves the data unchanged.
- R7: Any two flipped bits set the double flag and clear the single flag. The data is passed through exactly as received.
- R8: A syndrome of 13 to 15 with odd overall parity is treated as uncorrectable. The double flag is set and the data is passed through as received.
- R9: The syndrome is the bitwise XOR of the received check bits 3..0 with the check bits recomputed from the received data.
- R10: A channel's input is ready whenever its output register is empty or is being taken in the same cycle. An accepted input appears at the output in the next cycle. While the output is valid and not ready, the output is held stable and no new input is accepted.
- R11: Under reset, both output valids are low and both inputs are ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_in_valid | input | 1 | Encode request valid |
| enc_in_ready | output | 1 | Encode channel can accept |
| enc_in_data | input | DATA_W | Byte to encode |
| enc_out_valid | output | 1 | Encode result valid |
| enc_out_ready | input | 1 | Consumer takes encode result |
| enc_out_data | output | DATA_W | Byte passed through |
| enc_out_check | output | PAR_W+1 | Check bits; MSB is overall parity |
| dec_in_valid | input | 1 | Decode request valid |
| dec_in_ready | output | 1 | Decode channel can accept |
| dec_in_data | input | DATA_W | Stored data byte |
| dec_in_check | input | PAR_W+1 | Stored check bits |
| dec_out_valid | output | 1 | Decode result valid |
| dec_out_ready | input | 1 | Consumer takes decode result |
| dec_out_data | output | DATA_W | Corrected data |
| dec_out_single | output | 1 | Single error found and corrected |
| dec_out_double | output | 1 | Uncorrectable error found |
| dec_out_syndrome | output | PAR_W | Hamming syndrome |

## Verification
The bench builds the block with its default DATA_W of 8, which gives PAR_W of 4 and a 13-bit stored word. At that size every data byte can be encoded. Every byte can also be decoded clean, with each of its 13 single flips, and with each of its 78 double flips. For a few bytes, all 32 check-bit patterns are decoded, which reaches the out-of-range syndromes. Stalled outputs are exercised on both channels to cover the hold and ready behaviour.

// File: rtl/secded_pkg.sv
package secded_pkg;

    localparam int unsigned MAX_DATA_W = 64;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_FIXED  = 2'd1,
        ERR_UNCORR = 2'd2
    } err_class_e;

    function automatic bit is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

    // Number of Hamming check bits for a data width (overall parity excluded)
    function automatic int unsigned par_bits(input int unsigned dw);
        int unsigned p;
        p = 1;
        for (int i = 0; i < 8; i++) begin
            if ((32'd1 << p) < dw + p + 1) p = p + 1;
        end
        return p;
    endfunction

    // Code position (1-based) of data bit k: k-th non power-of-two index
    function automatic int unsigned data_pos(input int unsigned k);
        int unsigned cnt;
        int unsigned pos;
        cnt = 0;
        pos = 0;
        for (int unsigned q = 1; q <= 2 * MAX_DATA_W; q++) begin
            if (!is_pow2(q)) begin
                if (cnt == k && pos == 0) pos = q;
                cnt = cnt + 1;
            end
        end
        return pos;
    endfunction

    // Data bits covered by Hamming check bit i
    function automatic logic [MAX_DATA_W-1:0] cover_mask(input int unsigned i,
                                                         input int unsigned dw);
        logic [MAX_DATA_W-1:0] m;
        m = '0;
        for (int unsigned k = 0; k < MAX_DATA_W; k++) begin
            if (k < dw) m[k] = ((data_pos(k) >> i) & 1) != 0;
        end
        return m;
    endfunction

endpackage

// File: rtl/secded_enc_core.sv
module secded_enc_core
    import secded_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned PAR_W  = par_bits(DATA_W)
) (
    input  logic [DATA_W-1:0] data,
    output logic [PAR_W:0]    check
);
    logic [PAR_W-1:0] ham;

    for (genvar i = 0; i < PAR_W; i++) begin : g_ham
        localparam logic [MAX_DATA_W-1:0] MASK = cover_mask(i, DATA_W);
        assign ham[i] = ^(data & MASK[DATA_W-1:0]);
    end

    assign check = {(^data) ^ (^ham), ham};
endmodule

// File: rtl/secded_dec_core.sv
module secded_dec_core
    import secded_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned PAR_W  = par_bits(DATA_W)
) (
    input  logic [DATA_W-1:0] rx_data,
    input  logic [PAR_W:0]    rx_check,
    output logic [DATA_W-1:0] fix_data,
    output logic [PAR_W-1:0]  syndrome,
    output err_class_e        err_class
);
    localparam int unsigned CODE_W = DATA_W + PAR_W;

    logic [PAR_W:0] re_check;
    logic           parity_bad;
    logic           syn_nz;
    logic           in_range;

    secded_enc_core #(.DATA_W(DATA_W), .PAR_W(PAR_W)) u_recalc (
        .data  (rx_data),
        .check (re_check)
    );

    assign syndrome   = rx_check[PAR_W-1:0] ^ re_check[PAR_W-1:0];
    // odd parity over the full stored word
    assign parity_bad = rx_check[PAR_W] ^ re_check[PAR_W] ^ (^syndrome);
    assign syn_nz     = |syndrome;
    assign in_range   = ({1'b0, syndrome} <= (PAR_W+1)'(CODE_W));

    always_comb begin
        if (!parity_bad) err_class = syn_nz ? ERR_UNCORR : ERR_NONE;
        else             err_class = in_range ? ERR_FIXED : ERR_UNCORR;
    end

    for (genvar k = 0; k < DATA_W; k++) begin : g_fix
        localparam logic [PAR_W-1:0] POS = PAR_W'(data_pos(k));
        assign fix_data[k] = rx_data[k] ^ ((err_class == ERR_FIXED) && (syndrome == POS));
    end
endmodule

// File: rtl/secded_pipe_stage.sv
module secded_pipe_stage #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) out_data <= in_data;
        end
    end
endmodule

// File: rtl/secded_codec.sv
module secded_codec
    import secded_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned PAR_W  = par_bits(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enc_in_valid,
    output logic              enc_in_ready,
    input  logic [DATA_W-1:0] enc_in_data,
    output logic              enc_out_valid,
    input  logic              enc_out_ready,
    output logic [DATA_W-1:0] enc_out_data,
    output logic [PAR_W:0]    enc_out_check,
    input  logic              dec_in_valid,
    output logic              dec_in_ready,
    input  logic [DATA_W-1:0] dec_in_data,
    input  logic [PAR_W:0]    dec_in_check,
    output logic              dec_out_valid,
    input  logic              dec_out_ready,
    output logic [DATA_W-1:0] dec_out_data,
    output logic              dec_out_single,
    output logic              dec_out_double,
    output logic [PAR_W-1:0]  dec_out_syndrome
);
    localparam int unsigned ENC_PW = DATA_W + PAR_W + 1;
    localparam int unsigned DEC_PW = DATA_W + PAR_W + 2;

    // encode path
    logic [PAR_W:0] enc_check;

    secded_enc_core #(.DATA_W(DATA_W), .PAR_W(PAR_W)) u_enc (
        .data  (enc_in_data),
        .check (enc_check)
    );

    secded_pipe_stage #(.W(ENC_PW)) u_enc_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (enc_in_valid),
        .in_ready  (enc_in_ready),
        .in_data   ({enc_check, enc_in_data}),
        .out_valid (enc_out_valid),
        .out_ready (enc_out_ready),
        .out_data  ({enc_out_check, enc_out_data})
    );

    // decode path
    logic [DATA_W-1:0] dec_fix;
    logic [PAR_W-1:0]  dec_syn;
    err_class_e        dec_cls;

    secded_dec_core #(.DATA_W(DATA_W), .PAR_W(PAR_W)) u_dec (
        .rx_data   (dec_in_data),
        .rx_check  (dec_in_check),
        .fix_data  (dec_fix),
        .syndrome  (dec_syn),
        .err_class (dec_cls)
    );

    secded_pipe_stage #(.W(DEC_PW)) u_dec_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (dec_in_valid),
        .in_ready  (dec_in_ready),
        .in_data   ({dec_cls == ERR_FIXED, dec_cls == ERR_UNCORR, dec_syn, dec_fix}),
        .out_valid (dec_out_valid),
        .out_ready (dec_out_ready),
        .out_data  ({dec_out_single, dec_out_double, dec_out_syndrome, dec_out_data})
    );
endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned PAR_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              enc_in_valid,
    input logic              enc_in_ready,
    input logic              enc_out_valid,
    input logic              enc_out_ready,
    input logic [DATA_W-1:0] enc_out_data,
    input logic [PAR_W:0]    enc_out_check,
    input logic              dec_in_valid,
    input logic              dec_in_ready,
    input logic              dec_out_valid,
    input logic              dec_out_ready,
    input logic [DATA_W-1:0] dec_out_data,
    input logic              dec_out_single,
    input logic              dec_out_double,
    input logic [PAR_W-1:0]  dec_out_syndrome
);
    // R10: stalled results are held
    a_r10_enc_hold: assert property (@(posedge clk) disable iff (rst)
        enc_out_valid && !enc_out_ready |=> enc_out_valid && $stable(enc_out_data) && $stable(enc_out_check));

    a_r10_dec_hold: assert property (@(posedge clk) disable iff (rst)
        dec_out_valid && !dec_out_ready |=> dec_out_valid && $stable(dec_out_data)
            && $stable(dec_out_syndrome) && $stable(dec_out_single) && $stable(dec_out_double));

    // R10: accepted input shows up next cycle
    a_r10_enc_accept: assert property (@(posedge clk) disable iff (rst)
        enc_in_valid && enc_in_ready |=> enc_out_valid);

    a_r10_dec_accept: assert property (@(posedge clk) disable iff (rst)
        dec_in_valid && dec_in_ready |=> dec_out_valid);

    // R7: the two flags never both high
    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        dec_out_valid |-> !(dec_out_single && dec_out_double));

    // R6: zero syndrome is never uncorrectable
    a_r6_zero_syn: assert property (@(posedge clk) disable iff (rst)
        dec_out_valid && dec_out_syndrome == '0 |-> !dec_out_double);

    // R11: outputs empty right after reset
    a_r11_reset_empty: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !enc_out_valid && !dec_out_valid && enc_in_ready && dec_in_ready);
endmodule

bind secded_codec secded_codec_chk #(.DATA_W(DATA_W), .PAR_W(PAR_W)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .enc_in_valid     (enc_in_valid),
    .enc_in_ready     (enc_in_ready),
    .enc_out_valid    (enc_out_valid),
    .enc_out_ready    (enc_out_ready),
    .enc_out_data     (enc_out_data),
    .enc_out_check    (enc_out_check),
    .dec_in_valid     (dec_in_valid),
    .dec_in_ready     (dec_in_ready),
    .dec_out_valid    (dec_out_valid),
    .dec_out_ready    (dec_out_ready),
    .dec_out_data     (dec_out_data),
    .dec_out_single   (dec_out_single),
    .dec_out_double   (dec_out_double),
    .dec_out_syndrome (dec_out_syndrome)
);

// File: tb/sim_secded_codec.sv
module sim_secded_codec;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enc_in_valid = 1'b0;
    logic       enc_in_ready;
    logic [7:0] enc_in_data = '0;
    logic       enc_out_valid;
    logic       enc_out_ready = 1'b1;
    logic [7:0] enc_out_data;
    logic [4:0] enc_out_check;
    logic       dec_in_valid = 1'b0;
    logic       dec_in_ready;
    logic [7:0] dec_in_data = '0;
    logic [4:0] dec_in_check = '0;
    logic       dec_out_valid;
    logic       dec_out_ready = 1'b1;
    logic [7:0] dec_out_data;
    logic       dec_out_single;
    logic       dec_out_double;
    logic [3:0] dec_out_syndrome;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    secded_codec u0 (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit pow2(input int v);
        return v != 0 && (v & (v - 1)) == 0;
    endfunction

    // stored word: bit 0 overall parity, bits 1..12 code positions
    function automatic logic [12:0] model_encode(input logic [7:0] d);
        logic [12:0] w;
        int k;
        w = '0;
        k = 0;
        for (int pos = 1; pos <= 12; pos++) begin
            if (!pow2(pos)) begin
                w[pos] = d[k];
                k++;
            end
        end
        for (int b = 0; b < 4; b++) begin
            logic p;
            p = 1'b0;
            for (int pos = 1; pos <= 12; pos++)
                if (((pos >> b) & 1) == 1 && pos != (1 << b)) p ^= w[pos];
            w[1 << b] = p;
        end
        w[0] = ^w[12:1];
        return w;
    endfunction

    function automatic logic [7:0] model_data(input logic [12:0] w);
        logic [7:0] d;
        int k;
        k = 0;
        d = '0;
        for (int pos = 1; pos <= 12; pos++) begin
            if (!pow2(pos)) begin
                d[k] = w[pos];
                k++;
            end
        end
        return d;
    endfunction

    function automatic logic [4:0] model_check(input logic [12:0] w);
        return {w[0], w[8], w[4], w[2], w[1]};
    endfunction

    task automatic run_enc(input logic [7:0] d);
        logic [12:0] w;
        logic [4:0]  ec;
        w  = model_encode(d);
        ec = model_check(w);
        @(negedge clk);
        enc_in_valid = 1'b1;
        enc_in_data  = d;
        @(posedge clk);
        @(negedge clk);
        enc_in_valid = 1'b0;
        check(enc_out_valid == 1'b1, "R10", "enc valid", enc_out_valid, 1);
        check(enc_out_check[3:0] == ec[3:0], "R1", "hamming bits", enc_out_check[3:0], ec[3:0]);
        check(enc_out_check[4] == ec[4], "R2", "overall parity", enc_out_check[4], ec[4]);
        check(enc_out_data == d, "R1", "data pass", enc_out_data, d);
    endtask

    task automatic run_dec(input logic [12:0] w);
        logic [3:0]  esyn;
        logic        eperr;
        logic        es;
        logic        ed2;
        logic [12:0] wc;
        logic [7:0]  ed;
        string       req;
        esyn = '0;
        for (int pos = 1; pos <= 12; pos++) if (w[pos]) esyn ^= 4'(pos);
        eperr = ^w;
        es  = 1'b0;
        ed2 = 1'b0;
        wc  = w;
        if (!eperr && esyn == 0) req = "R3";
        else if (eperr && esyn == 0) begin req = "R6"; es = 1'b1; end
        else if (eperr && esyn <= 12) begin
            es = 1'b1;
            wc[esyn] = ~wc[esyn];
            req = pow2(int'(esyn)) ? "R5" : "R4";
        end else if (!eperr) begin req = "R7"; ed2 = 1'b1; end
        else begin req = "R8"; ed2 = 1'b1; end
        ed = model_data(wc);
        @(negedge clk);
        dec_in_valid = 1'b1;
        dec_in_data  = model_data(w);
        dec_in_check = model_check(w);
        @(posedge clk);
        @(negedge clk);
        dec_in_valid = 1'b0;
        check(dec_out_valid == 1'b1, "R10", "dec valid", dec_out_valid, 1);
        check(dec_out_data == ed, req, "data", dec_out_data, ed);
        check(dec_out_single == es, req, "single", dec_out_single, es);
        check(dec_out_double == ed2, req, "double", dec_out_double, ed2);
        check(dec_out_syndrome == esyn, "R9", "syndrome", dec_out_syndrome, esyn);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: state under reset
        check(!enc_out_valid && !dec_out_valid, "R11", "out valid in reset",
              {enc_out_valid, dec_out_valid}, 0);
        check(enc_in_ready && dec_in_ready, "R11", "in ready in reset",
              {enc_in_ready, dec_in_ready}, 3);
        rst = 1'b0;

        for (int d = 0; d < 256; d++) run_enc(8'(d));

        for (int d = 0; d < 256; d++) begin
            logic [12:0] w;
            w = model_encode(8'(d));
            run_dec(w);
            for (int i = 0; i < 13; i++) run_dec(w ^ (13'd1 << i));
            for (int i = 0; i < 13; i++)
                for (int j = i + 1; j < 13; j++)
                    run_dec(w ^ (13'd1 << i) ^ (13'd1 << j));
        end

        // R8: every check pattern for a few bytes reaches syndromes 13..15
        for (int s = 0; s < 4; s++) begin
            logic [7:0] d;
            d = (s == 0) ? 8'h00 : (s == 1) ? 8'hA5 : (s == 2) ? 8'hFF : 8'h3C;
            for (int c = 0; c < 32; c++) begin
                logic [12:0] w;
                w = model_encode(d);
                w[0] = c[4]; w[8] = c[3]; w[4] = c[2]; w[2] = c[1]; w[1] = c[0];
                run_dec(w);
            end
        end

        // R10: stall on decode channel
        begin
            logic [12:0] wa;
            logic [12:0] wb;
            wa = model_encode(8'h5A) ^ 13'h008;
            wb = model_encode(8'hC3);
            @(negedge clk);
            dec_out_ready = 1'b0;
            dec_in_valid  = 1'b1;
            dec_in_data   = model_data(wa);
            dec_in_check  = model_check(wa);
            @(posedge clk);
            @(negedge clk);
            dec_in_data  = model_data(wb);
            dec_in_check = model_check(wb);
            for (int t = 0; t < 3; t++) begin
                check(dec_in_ready == 1'b0, "R10", "dec ready while stalled", dec_in_ready, 0);
                check(dec_out_valid && dec_out_data == 8'h5A && dec_out_syndrome == 4'd3,
                      "R10", "dec held data", dec_out_data, 8'h5A);
                @(negedge clk);
            end
            dec_out_ready = 1'b1;
            @(posedge clk);
            @(negedge clk);
            dec_in_valid = 1'b0;
            check(dec_out_valid && dec_out_data == 8'hC3 && !dec_out_single,
                  "R10", "dec next after release", dec_out_data, 8'hC3);
        end

        // R10: stall on encode channel
        begin
            logic [4:0] ea;
            ea = model_check(model_encode(8'h81));
            @(negedge clk);
            enc_out_ready = 1'b0;
            enc_in_valid  = 1'b1;
            enc_in_data   = 8'h81;
            @(posedge clk);
            @(negedge clk);
            enc_in_data = 8'h7E;
            for (int t = 0; t < 3; t++) begin
                check(enc_in_ready == 1'b0, "R10", "enc ready while stalled", enc_in_ready, 0);
                check(enc_out_valid && enc_out_check == ea && enc_out_data == 8'h81,
                      "R10", "enc held check", enc_out_check, ea);
                @(negedge clk);
            end
            enc_out_ready = 1'b1;
            @(posedge clk);
            @(negedge clk);
            enc_in_valid = 1'b0;
            check(enc_out_valid && enc_out_data == 8'h7E, "R10", "enc next after release",
                  enc_out_data, 8'h7E);
            @(posedge clk);
            @(negedge clk);
            check(!enc_out_valid, "R10", "enc empties", enc_out_valid, 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule